// File: doc/BRIEF.md
# Six-Phase Instruction Sequencer with Masked Jump and ALU Mode Decode

This block is the control sequencer of a small CPU whose instructions are one byte wide: the upper nibble is the opcode and the lower nibble is an immediate. A counter walks through six phases per instruction. Phase 0 fetches the byte into an instruction register and phase 1 advances the program counter. Phases 2 and 3 run the opcode's own work. Phases 4 and 5 are idle slots. For each opcode and phase, a microcode table that sees only the opcode and the phase number gives the control strobes.

Two small pieces of logic sit beside the table. The first resolves conditional jumps. The single jump opcode has its active-low jump strobe gated by a two-bit mask taken from the immediate, and the active-low carry and zero flags take part in that gating. The result drives an active-low program-counter load. The second sets the ALU math/logic selector from the opcode number alone. The math opcodes are placed at 0 and 1 so that the selector is a plain OR of the three upper opcode bits. The flags never reach the table, so the table holds exactly one entry per opcode and phase.

Top module: `ctl_sequencer`

## Requirements
- R1: While `rst_n` is low, the phase is 0 and the captured opcode and immediate are 0. The outputs then read `ctrl_o` = 0x003, `pc_load_n` = 1, `alu_mode` = 0 and `imm_o` = 0.
- R2: The phase advances by one on every clock and wraps from 5 to 0. `ctrl_o` is 0x003 in every phase 0 (bit 0 fetch-enable, bit 1 instruction-load) and 0x004 in every phase 1 (bit 2 PC-increment).
- R3: The instruction byte is captured only at the clock edge that ends phase 0. Bits [7:4] are the opcode and bits [3:0] are the immediate, and the immediate is shown on `imm_o`. Changes on `instr_i` during phases 1 to 5 have no effect on any output.
- R4: In phases 2 and 3 the table gives these words. The bits are: 3 A-load, 4 B-load, 5 immediate-enable, 6 ALU-enable, 7 carry-in-enable, 8 flag-load, 9 RAM-write, 10 RAM-read, 11 output-load, 12 input-enable. Phase 2 gives 0x0C8 for opcode 0, 0x048 for opcodes 1 and 2, 0x028 for 3, 0x030 for 4, 0x220 for 5, 0x428 for 6, 0x800 for 7 and 0x1008 for 8. Phase 3 gives 0x100 for opcodes 0 to 2. Every other opcode/phase pair gives 0, including jump opcode 9.
- R5: `ctrl_o` does not depend on `carry_n` or `zero_n` for any opcode or phase.
- R6: In phase 2 of opcode 9 with immediate bits [1:0] = 11, `pc_load_n` is 0 whatever the flags are.
- R7: In phase 2 of opcode 9 with mask 01, `pc_load_n` is 0 exactly when `carry_n` is 0.
- R8: In phase 2 of opcode 9 with mask 10, `pc_load_n` is 0 exactly when `zero_n` is 0.
- R9: Mask 00 never loads the PC. `pc_load_n` is 1 in every phase other than phase 2 of opcode 9.
- R10: `alu_mode` equals the OR of captured opcode bits [3:1]. It is 0 (math) for opcodes 0 and 1 and 1 (logic) for opcodes 2 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| instr_i | input | 8 | Instruction byte from program memory |
| carry_n | input | 1 | Carry flag, active low |
| zero_n | input | 1 | Zero flag, active low |
| ctrl_o | output | 13 | Control strobes, active high |
| imm_o | output | 4 | Captured immediate nibble |
| pc_load_n | output | 1 | Program-counter load, active low |
| alu_mode | output | 1 | ALU selector: 0 math, 1 logic |

## Verification
Every one of the 16 opcodes is run through all six phases, and each opcode is paired with a different flag setting. This separates the table entries from one another and shows that the strobes ignore the flags. The jump opcode is run with all four masks against all four flag combinations. Those 16 cases tell unconditional, carry-gated, zero-gated and never-taken behaviour apart, and they catch a swap of carry and zero. Some runs drive the complement of the instruction byte during phases 1 to 5, which exposes any capture outside phase 0. Each phase 0 is checked against the ALU selector left over from the previous instruction, which pins down exactly when the register loads.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W    = 4;
  localparam int IMM_W   = 4;
  localparam int INSTR_W = OP_W + IMM_W;
  localparam int PHASES  = 6;
  localparam int PH_W    = $clog2(PHASES);
  localparam int CW      = 13;
  localparam int MASK_W  = 2;

  localparam int PH_FETCH = 0;
  localparam int PH_INC   = 1;
  localparam int PH_EXEC  = 2;
  localparam int PH_FLAG  = 3;

  // strobe bit positions
  localparam int S_FETCH  = 0;
  localparam int S_IRLD   = 1;
  localparam int S_PCINC  = 2;
  localparam int S_ALD    = 3;
  localparam int S_BLD    = 4;
  localparam int S_IMMOE  = 5;
  localparam int S_ALUOE  = 6;
  localparam int S_CIN    = 7;
  localparam int S_FLGLD  = 8;
  localparam int S_RAMWE  = 9;
  localparam int S_RAMOE  = 10;
  localparam int S_OUTLD  = 11;
  localparam int S_INOE   = 12;

  typedef enum logic [OP_W-1:0] {
    OP_MWC = 4'h0,
    OP_MNC = 4'h1,
    OP_LOG = 4'h2,
    OP_LDA = 4'h3,
    OP_LDB = 4'h4,
    OP_STA = 4'h5,
    OP_LDM = 4'h6,
    OP_OUT = 4'h7,
    OP_INP = 4'h8,
    OP_JMP = 4'h9
  } op_e;

  typedef struct packed {
    logic          jmp_n;
    logic [CW-1:0] strobe;
  } uword_t;
endpackage

// File: rtl/ctl_phase_ring.sv
module ctl_phase_ring
  import ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    if (ph_q == LAST) ph_d = '0;
    else              ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign ph_o = ph_q;
endmodule

// File: rtl/ctl_ucode.sv
module ctl_ucode
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [PH_W-1:0] ph_i,
  output uword_t          word_o
);
  logic [CW-1:0] exec_w;
  logic [CW-1:0] flag_w;
  logic          exec_jmp_n;

  always_comb begin
    exec_w     = '0;
    exec_jmp_n = 1'b1;
    unique case (op_e'(op_i))
      OP_MWC: begin
        exec_w[S_ALUOE] = 1'b1;
        exec_w[S_ALD]   = 1'b1;
        exec_w[S_CIN]   = 1'b1;
      end
      OP_MNC, OP_LOG: begin
        exec_w[S_ALUOE] = 1'b1;
        exec_w[S_ALD]   = 1'b1;
      end
      OP_LDA: begin
        exec_w[S_IMMOE] = 1'b1;
        exec_w[S_ALD]   = 1'b1;
      end
      OP_LDB: begin
        exec_w[S_IMMOE] = 1'b1;
        exec_w[S_BLD]   = 1'b1;
      end
      OP_STA: begin
        exec_w[S_IMMOE] = 1'b1;
        exec_w[S_RAMWE] = 1'b1;
      end
      OP_LDM: begin
        exec_w[S_IMMOE] = 1'b1;
        exec_w[S_RAMOE] = 1'b1;
        exec_w[S_ALD]   = 1'b1;
      end
      OP_OUT: exec_w[S_OUTLD] = 1'b1;
      OP_INP: begin
        exec_w[S_INOE] = 1'b1;
        exec_w[S_ALD]  = 1'b1;
      end
      OP_JMP: exec_jmp_n = 1'b0;
      default: ;
    endcase
  end

  always_comb begin
    flag_w = '0;
    unique case (op_e'(op_i))
      OP_MWC, OP_MNC, OP_LOG: flag_w[S_FLGLD] = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    word_o.strobe = '0;
    word_o.jmp_n  = 1'b1;
    case (ph_i)
      PH_W'(PH_FETCH): begin
        word_o.strobe[S_FETCH] = 1'b1;
        word_o.strobe[S_IRLD]  = 1'b1;
      end
      PH_W'(PH_INC):  word_o.strobe[S_PCINC] = 1'b1;
      PH_W'(PH_EXEC): begin
        word_o.strobe = exec_w;
        word_o.jmp_n  = exec_jmp_n;
      end
      PH_W'(PH_FLAG): word_o.strobe = flag_w;
      default: ;
    endcase
  end
endmodule

// File: rtl/ctl_jump_gate.sv
module ctl_jump_gate
  import ctl_pkg::*;
(
  input  logic              jmp_n_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              carry_n,
  input  logic              zero_n,
  output logic              pc_load_n
);
  logic [MASK_W-1:0] flag_n;
  logic [MASK_W-1:0] term;

  assign flag_n = {zero_n, carry_n};

  for (genvar g = 0; g < MASK_W; g++) begin : g_term
    // each mask bit enables its flag; the partner bit forces the path open
    assign term[g] = mask_i[g] & (mask_i[(g + 1) % MASK_W] | ~flag_n[g]);
  end

  assign pc_load_n = jmp_n_i | ~(|term);
endmodule

// File: rtl/ctl_alu_mode.sv
module ctl_alu_mode
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            mode_o
);
  logic [OP_W-1:1] chain;

  assign chain[OP_W-1] = op_i[OP_W-1];
  for (genvar g = OP_W - 2; g >= 1; g--) begin : g_or
    assign chain[g] = chain[g+1] | op_i[g];
  end

  assign mode_o = chain[1];
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               carry_n,
  input  logic               zero_n,
  output logic [CW-1:0]      ctrl_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic               pc_load_n,
  output logic               alu_mode
);
  logic [PH_W-1:0]    ph;
  logic [INSTR_W-1:0] ir_q;
  logic [INSTR_W-1:0] ir_d;
  logic               ir_en;
  uword_t             uw;

  ctl_phase_ring u_ring (
    .clk  (clk),
    .rst_n(rst_n),
    .ph_o (ph)
  );

  assign ir_en = (ph == PH_W'(PH_FETCH));

  always_comb begin
    ir_d = ir_q;
    if (ir_en) ir_d = instr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= '0;
    else        ir_q <= ir_d;
  end

  ctl_ucode u_ucode (
    .op_i  (ir_q[INSTR_W-1:IMM_W]),
    .ph_i  (ph),
    .word_o(uw)
  );

  ctl_jump_gate u_jgate (
    .jmp_n_i  (uw.jmp_n),
    .mask_i   (ir_q[MASK_W-1:0]),
    .carry_n  (carry_n),
    .zero_n   (zero_n),
    .pc_load_n(pc_load_n)
  );

  ctl_alu_mode u_mode (
    .op_i  (ir_q[INSTR_W-1:IMM_W]),
    .mode_o(alu_mode)
  );

  assign ctrl_o = uw.strobe;
  assign imm_o  = ir_q[IMM_W-1:0];
endmodule

// File: rtl/ctl_sequencer_chk.sv
module ctl_sequencer_chk
  import ctl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [PH_W-1:0]    ph,
  input logic [INSTR_W-1:0] ir,
  input logic [CW-1:0]      ctrl_o,
  input logic               carry_n,
  input logic               zero_n,
  input logic               pc_load_n,
  input logic               alu_mode
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);
  logic [OP_W-1:0]   op;
  logic [MASK_W-1:0] mask;
  assign op   = ir[INSTR_W-1:IMM_W];
  assign mask = ir[MASK_W-1:0];

  p_ring_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == LAST) |=> (ph == '0));
  p_ring_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != LAST) |=> (ph == $past(ph) + 1'b1));
  p_fetch_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_W'(PH_FETCH)) |-> (ctrl_o[S_FETCH] && ctrl_o[S_IRLD]));
  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_W'(PH_FETCH)) |=> $stable(ir));
  p_uncond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_W'(PH_EXEC) && op == OP_JMP && mask == 2'b11) |-> !pc_load_n);
  p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_W'(PH_EXEC) && op == OP_JMP && mask == 2'b01) |-> (pc_load_n == carry_n));
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_W'(PH_EXEC) && op == OP_JMP && mask == 2'b10) |-> (pc_load_n == zero_n));
  p_load_only_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load_n |-> (ph == PH_W'(PH_EXEC) && op == OP_JMP && mask != 2'b00));
  p_math_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op[OP_W-1:1] == '0) |-> !alu_mode);
  p_logic_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op[OP_W-1:1] != '0) |-> alu_mode);
endmodule

bind ctl_sequencer ctl_sequencer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ph       (ph),
  .ir       (ir_q),
  .ctrl_o   (ctrl_o),
  .carry_n  (carry_n),
  .zero_n   (zero_n),
  .pc_load_n(pc_load_n),
  .alu_mode (alu_mode)
);

// File: tb/test_ctl_sequencer.sv
module test_ctl_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  instr_i;
  logic        carry_n;
  logic        zero_n;
  logic [12:0] ctrl_o;
  logic [3:0]  imm_o;
  logic        pc_load_n;
  logic        alu_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [3:0] prev_op = 4'h0;
  logic [3:0] prev_imm = 4'h0;

  always #2 clk = ~clk;

  ctl_sequencer i_ctl_sequencer (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .carry_n(carry_n),
    .zero_n(zero_n), .ctrl_o(ctrl_o), .imm_o(imm_o),
    .pc_load_n(pc_load_n), .alu_mode(alu_mode)
  );

  task automatic check(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // R2/R4 expected strobe words
  function automatic logic [12:0] exp_word(input logic [3:0] op, input int p);
    case (p)
      0: return 13'h003;
      1: return 13'h004;
      2: case (op)
           4'h0: return 13'h0C8;
           4'h1, 4'h2: return 13'h048;
           4'h3: return 13'h028;
           4'h4: return 13'h030;
           4'h5: return 13'h220;
           4'h6: return 13'h428;
           4'h7: return 13'h800;
           4'h8: return 13'h1008;
           default: return 13'h000;
         endcase
      3: return (op <= 4'h2) ? 13'h100 : 13'h000;
      default: return 13'h000;
    endcase
  endfunction

  // R6..R9 expected PC load in the jump's execute phase
  function automatic logic exp_load_n(input logic [1:0] m, input logic c, input logic z);
    case (m)
      2'b11: return 1'b0;
      2'b01: return c;
      2'b10: return z;
      default: return 1'b1;
    endcase
  endfunction

  // runs one instruction, entered and left at a negedge in phase 0
  task automatic run_instr(input logic [7:0] b, input logic c, input logic z,
                           input bit scramble, input string tag);
    logic [3:0] op;
    logic exp_pl;
    op = b[7:4];
    for (int p = 0; p < 6; p++) begin
      if (p == 0) begin
        instr_i = b; carry_n = c; zero_n = z;
      end else if (scramble) begin
        instr_i = ~b;
      end
      #1;
      if (p == 0) begin
        check(ctrl_o, 13'h003, {tag, " R2 fetch word"});
        check(alu_mode, |prev_op[3:1], {tag, " R3 mode held before capture"});
        check(imm_o, prev_imm, {tag, " R3 imm held before capture"});
      end else begin
        check(ctrl_o, exp_word(op, p), $sformatf("%s R4/R5 op %0h phase %0d", tag, op, p));
        check(alu_mode, |op[3:1], $sformatf("%s R10 op %0h", tag, op));
        check(imm_o, b[3:0], {tag, " R3 immediate"});
      end
      exp_pl = (p == 2 && op == 4'h9) ? exp_load_n(b[1:0], c, z) : 1'b1;
      check(pc_load_n, exp_pl, $sformatf("%s R6-9 pc_load_n mask %0b c%0b z%0b phase %0d",
                                         tag, b[1:0], c, z, p));
      @(negedge clk);
    end
    prev_op  = op;
    prev_imm = b[3:0];
  endtask

  task automatic t_reset();
    rst_n = 1'b0; instr_i = 8'hA5; carry_n = 1'b1; zero_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ctrl_o, 13'h003, "R1 ctrl in reset");
    check(pc_load_n, 1, "R1 pc_load_n in reset");
    check(alu_mode, 0, "R1 alu_mode in reset");
    check(imm_o, 0, "R1 imm in reset");
    rst_n = 1'b1;
    prev_op = 4'h0; prev_imm = 4'h0;
  endtask

  task automatic t_all_ops();
    for (int o = 0; o < 16; o++) begin
      run_instr({o[3:0], o[3:0] ^ 4'h6}, o[0], o[1], 1'b0, "ops");
    end
  endtask

  task automatic t_flags_ignored();
    // R5: same non-jump opcode under every flag pair
    for (int f = 0; f < 4; f++) begin
      run_instr(8'h0E, f[0], f[1], 1'b0, "R5 mwc");
      run_instr(8'h6C, f[0], f[1], 1'b0, "R5 ldm");
    end
  endtask

  task automatic t_jump_masks();
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 4; f++) begin
        run_instr({4'h9, 2'b10, m[1:0]}, f[0], f[1], 1'b0, "jmp");
      end
    end
  endtask

  task automatic t_ir_hold();
    // R3: byte changes after phase 0 must not leak
    run_instr(8'h31, 1'b1, 1'b1, 1'b1, "R3 hold lda");
    run_instr(8'h9E, 1'b1, 1'b0, 1'b1, "R3 hold jmp");
    run_instr(8'h1F, 1'b0, 1'b0, 1'b1, "R3 hold mnc");
  endtask

  initial begin
    t_reset();
    t_all_ops();
    t_flags_ignored();
    t_jump_masks();
    t_ir_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule